// File: doc/BRIEF.md
# Lockable Graphics Mode Selector

This block holds one byte of configuration space that picks between two graphics arrangements: an external graphics port, or an on-chip graphics function. It also drives the routing that follows from that choice. A host reaches the byte through a simple register bus that carries a function number and a byte offset. The byte contains three control bits: a mode select, a global enable for aperture accesses, and a lock. The lock can be loaded once after reset. When it is set, the mode select is frozen until the next reset.

The block sits in front of the register files of configuration functions 0, 1 and 2. From the mode select it works out which function answers each access. It forwards a write strobe only to the register file that is visible. It returns all ones for functions that are hidden, and returns zeros for the external-port registers of function 0 while the on-chip graphics function is selected. It produces the on-chip graphics function's enable for answering configuration cycles. It also gates every port's aperture grant with the global enable.

Top module: `gfx_mode_sel`

## Requirements
- R1: After reset the control byte reads 0x00, `aper_en` is 0 and `gfx_cfg_en` is 0.
- R2: The control byte sits in function 0 at offset 0x51. Bit 0 is the mode (0 = external port, 1 = on-chip graphics), bit 1 is the aperture enable and bit 2 is the lock. Bits 7:3 always read 0, and writing them has no effect.
- R3: Read data appears on `cfg_rdata` in the cycle after `cfg_rd` is sampled high. It holds that value until the next read.
- R4: The first write to the control byte after reset loads bit 2 with the written value, whether 0 or 1. Every later write leaves bit 2 unchanged until reset.
- R5: While bit 2 is 1, writes do not change bit 0. A write that sets bit 2 still updates bit 0, because the lock is still clear during that write. Bit 1 is writable at all times.
- R6: In external mode (bit 0 = 0), reads of functions 0 and 1 return the data from their register files, and reads of function 2 return 0xFF. `fn_wr[0]` and `fn_wr[1]` can pulse, but `fn_wr[2]` stays 0.
- R7: In on-chip mode (bit 0 = 1), reads of function 1 return 0xFF and reads of function 2 pass through. Function 0 reads at offsets 0xA0 to 0xAF return 0x00, and other function 0 reads pass through. `fn_wr[1]` stays 0.
- R8: Reads of function 3 return 0xFF in both modes. A write to function 0 offset 0x51 raises no `fn_wr` bit. Otherwise, `fn_wr[f]` is high in the same cycle as `cfg_wr` when function f is visible.
- R9: `gfx_cfg_en` is 1 exactly when bit 0 is 1 and `smram_mode` is not 00.
- R10: `aper_en` equals bit 1. Each `port_gnt[i]` equals `port_req[i]` while `aper_en` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_fn | input | 2 | Target configuration function |
| cfg_addr | input | 8 | Byte offset within the function |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| f0_rdata | input | 8 | Read data from the function 0 register file |
| f1_rdata | input | 8 | Read data from the function 1 register file |
| f2_rdata | input | 8 | Read data from the function 2 register file |
| fn_wr | output | 3 | Write strobes forwarded to functions 0..2 |
| smram_mode | input | 2 | Memory-window field from another register |
| gfx_cfg_en | output | 1 | On-chip graphics answers configuration cycles |
| aper_en | output | 1 | Aperture access enable |
| port_req | input | NPORTS | Aperture requests, one per port |
| port_gnt | output | NPORTS | Gated aperture grants |

## Verification
The bench targets the lock's corner cases. A first write of 0 to bit 2 must still use up the one chance to set it. A design that treated only a written 1 as final could be locked later. A write that sets the lock together with the mode must still take the mode; a design that used the new lock value would drop it. The edges of the 0xA0 to 0xAF range are read in both modes, because an off-by-one decode would zero a neighbouring register or leak an external-port register. Random traffic mixes mode changes with reads and writes to every function. A swapped visibility rule would show up as 0xFF or as pass-through data where the other is expected, or as a strobe reaching a hidden function.

// File: rtl/gms_pkg.sv
package gms_pkg;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       lock;
        logic       aper;
        logic       mode;
    } ctrl_t;

    typedef enum logic [1:0] {
        FN_HOST = 2'd0,
        FN_PORT = 2'd1,
        FN_GFX  = 2'd2,
        FN_NONE = 2'd3
    } fn_e;

    localparam logic [7:0] ALL_ONES = 8'hFF;

    function automatic logic in_range(input logic [7:0] a,
                                      input logic [7:0] lo,
                                      input logic [7:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/gms_ctrl_reg.sv
module gms_ctrl_reg
    import gms_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit_wr,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl,
    output logic       lock_used
);
    ctrl_t wv;
    assign wv = ctrl_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            lock_used <= 1'b0;
        end else if (hit_wr) begin
            ctrl.aper <= wv.aper;
            if (!ctrl.lock) begin
                ctrl.mode <= wv.mode;
            end
            if (!lock_used) begin
                ctrl.lock <= wv.lock;
                lock_used <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/gms_route.sv
module gms_route
    import gms_pkg::*;
#(
    parameter logic [7:0] CTRL_OFS = 8'h51,
    parameter logic [7:0] PORT_LO  = 8'hA0,
    parameter logic [7:0] PORT_HI  = 8'hAF
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic       cfg_rd,
    input  logic [1:0] cfg_fn,
    input  logic [7:0] cfg_addr,
    input  ctrl_t      ctrl,
    input  logic [7:0] f0_rdata,
    input  logic [7:0] f1_rdata,
    input  logic [7:0] f2_rdata,
    output logic       hit_wr,
    output logic [2:0] fn_wr,
    output logic [7:0] cfg_rdata
);
    fn_e        fn;
    logic       own_hit;
    logic [2:0] vis;
    logic [7:0] rd_next;

    assign fn      = fn_e'(cfg_fn);
    assign own_hit = (fn == FN_HOST) && (cfg_addr == CTRL_OFS);
    assign hit_wr  = cfg_wr && own_hit;

    assign vis[0] = 1'b1;
    assign vis[1] = !ctrl.mode;
    assign vis[2] = ctrl.mode;

    always_comb begin
        fn_wr = '0;
        if (cfg_wr && !own_hit && fn != FN_NONE) begin
            fn_wr[cfg_fn] = vis[cfg_fn];
        end
    end

    always_comb begin
        case (fn)
            FN_HOST: begin
                if (own_hit) begin
                    rd_next = {5'b0, ctrl.lock, ctrl.aper, ctrl.mode};
                end else if (ctrl.mode && in_range(cfg_addr, PORT_LO, PORT_HI)) begin
                    rd_next = 8'h00;
                end else begin
                    rd_next = f0_rdata;
                end
            end
            FN_PORT: rd_next = vis[1] ? f1_rdata : ALL_ONES;
            FN_GFX:  rd_next = vis[2] ? f2_rdata : ALL_ONES;
            default: rd_next = ALL_ONES;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rdata <= '0;
        end else if (cfg_rd) begin
            cfg_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/gms_gate.sv
module gms_gate #(
    parameter int NPORTS = 3
)(
    input  logic              enable,
    input  logic [NPORTS-1:0] req,
    output logic [NPORTS-1:0] gnt
);
    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        assign gnt[i] = req[i] & enable;
    end
endmodule

// File: rtl/gfx_mode_sel.sv
module gfx_mode_sel
    import gms_pkg::*;
#(
    parameter int         NPORTS   = 3,
    parameter logic [7:0] CTRL_OFS = 8'h51,
    parameter logic [7:0] PORT_LO  = 8'hA0,
    parameter logic [7:0] PORT_HI  = 8'hAF
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [1:0]        cfg_fn,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [7:0]        f0_rdata,
    input  logic [7:0]        f1_rdata,
    input  logic [7:0]        f2_rdata,
    output logic [2:0]        fn_wr,
    input  logic [1:0]        smram_mode,
    output logic              gfx_cfg_en,
    output logic              aper_en,
    input  logic [NPORTS-1:0] port_req,
    output logic [NPORTS-1:0] port_gnt
);
    ctrl_t ctrl;
    logic  hit_wr;
    logic  lock_used;
    logic  mode_q;
    logic  lock_q;

    gms_ctrl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .hit_wr    (hit_wr),
        .wdata     (cfg_wdata),
        .ctrl      (ctrl),
        .lock_used (lock_used)
    );

    gms_route #(
        .CTRL_OFS (CTRL_OFS),
        .PORT_LO  (PORT_LO),
        .PORT_HI  (PORT_HI)
    ) u_route (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_fn    (cfg_fn),
        .cfg_addr  (cfg_addr),
        .ctrl      (ctrl),
        .f0_rdata  (f0_rdata),
        .f1_rdata  (f1_rdata),
        .f2_rdata  (f2_rdata),
        .hit_wr    (hit_wr),
        .fn_wr     (fn_wr),
        .cfg_rdata (cfg_rdata)
    );

    assign mode_q     = ctrl.mode;
    assign lock_q     = ctrl.lock;
    assign aper_en    = ctrl.aper;
    assign gfx_cfg_en = mode_q && (smram_mode != 2'b00);

    gms_gate #(.NPORTS(NPORTS)) u_gate (
        .enable (aper_en),
        .req    (port_req),
        .gnt    (port_gnt)
    );
endmodule

// File: rtl/gfx_mode_sel_chk.sv
module gfx_mode_sel_chk #(
    parameter int         NPORTS   = 3,
    parameter logic [7:0] CTRL_OFS = 8'h51
)(
    input logic              clk,
    input logic              rst,
    input logic              cfg_rd,
    input logic [1:0]        cfg_fn,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_rdata,
    input logic [2:0]        fn_wr,
    input logic              mode_q,
    input logic              lock_q,
    input logic              lock_used,
    input logic              aper_en,
    input logic [NPORTS-1:0] port_gnt
);
    // R4
    lock_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        $past(lock_used) |-> $stable(lock_q));

    // R5
    mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        $past(lock_q) |-> $stable(mode_q));

    // R10
    gnt_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        !aper_en |-> (port_gnt == '0));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rd) && $past(cfg_fn) == 2'd0 && $past(cfg_addr) == CTRL_OFS)
        |-> (cfg_rdata[7:3] == 5'b0));

    // R6
    hidden_gfx_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rd) && $past(cfg_fn) == 2'd2 && !$past(mode_q)) |-> (cfg_rdata == 8'hFF));

    // R7
    hidden_port_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rd) && $past(cfg_fn) == 2'd1 && $past(mode_q)) |-> (cfg_rdata == 8'hFF));

    // R8
    strobe_vis_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fn_wr) && (fn_wr[2] -> mode_q) && (fn_wr[1] -> !mode_q));
endmodule

bind gfx_mode_sel gfx_mode_sel_chk #(.NPORTS(NPORTS), .CTRL_OFS(CTRL_OFS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rd    (cfg_rd),
    .cfg_fn    (cfg_fn),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .fn_wr     (fn_wr),
    .mode_q    (mode_q),
    .lock_q    (lock_q),
    .lock_used (lock_used),
    .aper_en   (aper_en),
    .port_gnt  (port_gnt)
);

// File: tb/test_gfx_mode_sel.sv
`timescale 1ns/1ps
module test_gfx_mode_sel;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [1:0]    cfg_fn = '0;
    logic [7:0]    cfg_addr = '0, cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic [7:0]    f0_rdata = '0, f1_rdata = '0, f2_rdata = '0;
    logic [2:0]    fn_wr;
    logic [1:0]    smram_mode = '0;
    logic          gfx_cfg_en, aper_en;
    logic [NP-1:0] port_req = '0, port_gnt;

    int total = 0;
    int bad   = 0;

    logic m_mode, m_aper, m_lock, m_used;
    logic [7:0] got;
    logic [2:0] seen_wr;

    always #2.5 clk = ~clk;

    gfx_mode_sel #(.NPORTS(NP)) i_gfx_mode_sel (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [1:0] fn, input logic [7:0] a,
                                          input logic [7:0] d0, input logic [7:0] d1,
                                          input logic [7:0] d2);
        if (fn == 2'd0) begin
            if (a == 8'h51) return {5'b0, m_lock, m_aper, m_mode};
            if (m_mode && a >= 8'hA0 && a <= 8'hAF) return 8'h00;
            return d0;
        end
        if (fn == 2'd1) return m_mode ? 8'hFF : d1;
        if (fn == 2'd2) return m_mode ? d2 : 8'hFF;
        return 8'hFF;
    endfunction

    function automatic logic [2:0] exp_wr(input logic [1:0] fn, input logic [7:0] a);
        if (fn == 2'd0) return (a == 8'h51) ? 3'b000 : 3'b001;
        if (fn == 2'd1) return m_mode ? 3'b000 : 3'b010;
        if (fn == 2'd2) return m_mode ? 3'b100 : 3'b000;
        return 3'b000;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_mode = 0; m_aper = 0; m_lock = 0; m_used = 0;
    endtask

    task automatic do_wr(input logic [1:0] fn, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_fn = fn; cfg_addr = a; cfg_wdata = d;
        #1 seen_wr = fn_wr;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (fn == 2'd0 && a == 8'h51) begin
            m_aper = d[1];
            if (!m_lock) m_mode = d[0];
            if (!m_used) begin m_lock = d[2]; m_used = 1'b1; end
        end
    endtask

    task automatic do_rd(input logic [1:0] fn, input logic [7:0] a);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_fn = fn; cfg_addr = a;
        @(negedge clk);
        cfg_rd = 1'b0;
        got = cfg_rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        smram_mode = 2'b11; port_req = 3'b111;
        #1;
        check("R1 aper_en", {7'b0, aper_en}, 8'h00);
        check("R1 gfx_cfg_en", {7'b0, gfx_cfg_en}, 8'h00);
        check("R10 gnt at reset", {5'b0, port_gnt}, 8'h00);
        do_rd(2'd0, 8'h51);
        check("R1 ctrl reset", got, 8'h00);

        do_wr(2'd0, 8'h51, 8'hFA);
        check("R8 own reg no strobe", {5'b0, seen_wr}, 8'h00);
        do_rd(2'd0, 8'h51);
        check("R2 reserved ignored", got, 8'h02);
        #1 check("R10 gnt follows req", {5'b0, port_gnt}, 8'h07);
        @(negedge clk);
        check("R3 rdata held", cfg_rdata, 8'h02);
        do_wr(2'd0, 8'h51, 8'h05);
        do_rd(2'd0, 8'h51);
        check("R4 lock spent by zero write", got, 8'h01);
        do_wr(2'd0, 8'h51, 8'h00);
        do_rd(2'd0, 8'h51);
        check("R5 mode writable unlocked", got, 8'h00);

        do_reset();
        do_wr(2'd0, 8'h51, 8'h07);
        do_rd(2'd0, 8'h51);
        check("R5 lock and mode same write", got, 8'h07);
        do_wr(2'd0, 8'h51, 8'h00);
        do_rd(2'd0, 8'h51);
        check("R5 mode frozen, aper writable", got, 8'h05);
        #1 check("R10 gnt blocked", {5'b0, port_gnt}, 8'h00);
        smram_mode = 2'b00; #1;
        check("R9 smram zero", {7'b0, gfx_cfg_en}, 8'h00);
        smram_mode = 2'b01; #1;
        check("R9 smram open", {7'b0, gfx_cfg_en}, 8'h01);

        f0_rdata = 8'h3C; f1_rdata = 8'h5A; f2_rdata = 8'hC3;
        do_rd(2'd1, 8'h10); check("R7 fn1 hidden", got, 8'hFF);
        do_rd(2'd2, 8'h10); check("R7 fn2 visible", got, 8'hC3);
        do_rd(2'd0, 8'hA0); check("R7 port low edge", got, 8'h00);
        do_rd(2'd0, 8'hAF); check("R7 port high edge", got, 8'h00);
        do_rd(2'd0, 8'h9F); check("R7 below range", got, 8'h3C);
        do_rd(2'd0, 8'hB0); check("R7 above range", got, 8'h3C);
        do_rd(2'd3, 8'h00); check("R8 fn3 gfx mode", got, 8'hFF);
        do_wr(2'd1, 8'h20, 8'h11); check("R7 fn1 strobe off", {5'b0, seen_wr}, 8'h00);
        do_wr(2'd2, 8'h20, 8'h11); check("R8 fn2 strobe", {5'b0, seen_wr}, 8'h04);

        do_reset();
        do_rd(2'd2, 8'h44); check("R6 fn2 hidden", got, 8'hFF);
        do_rd(2'd1, 8'h44); check("R6 fn1 visible", got, 8'h5A);
        do_rd(2'd0, 8'hA5); check("R6 port reg passes", got, 8'h3C);
        do_rd(2'd3, 8'h44); check("R8 fn3 ext mode", got, 8'hFF);
        do_wr(2'd2, 8'h44, 8'h00); check("R6 fn2 strobe off", {5'b0, seen_wr}, 8'h00);
        do_wr(2'd1, 8'h44, 8'h00); check("R6 fn1 strobe", {5'b0, seen_wr}, 8'h02);

        for (int i = 0; i < 400; i++) begin
            logic [1:0] fn;
            logic [7:0] a;
            int kind;
            kind = $urandom_range(0, 9);
            fn = 2'($urandom_range(0, 3));
            a = (kind < 3) ? 8'h51 : ((kind < 6) ? 8'($urandom_range(8'h9E, 8'hB1)) : 8'($urandom));
            f0_rdata = 8'($urandom); f1_rdata = 8'($urandom); f2_rdata = 8'($urandom);
            smram_mode = 2'($urandom); port_req = 3'($urandom);
            if (kind == 9) begin
                do_reset();
            end else if (kind < 2) begin
                do_wr(2'd0, 8'h51, 8'($urandom));
            end else if (kind < 5) begin
                logic [2:0] ew;
                ew = exp_wr(fn, a);
                do_wr(fn, a, 8'($urandom));
                check("R8 random strobe", {5'b0, seen_wr}, {5'b0, ew});
            end else begin
                logic [7:0] er;
                er = exp_rd(fn, a, f0_rdata, f1_rdata, f2_rdata);
                do_rd(fn, a);
                check("R7 random read", got, er);
            end
            #1;
            check("R9 random gfx_cfg_en", {7'b0, gfx_cfg_en},
                  {7'b0, m_mode && (smram_mode != 2'b00)});
            check("R10 random gnt", {5'b0, port_gnt}, {5'b0, port_req & {NP{m_aper}}});
        end

        do_rd(2'd0, 8'h51);
        check("R4 final ctrl", got, {5'b0, m_lock, m_aper, m_mode});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule